// File: doc/BRIEF.md
# Command-Encoded GPIO Pin Bank

This block is a bank of general-purpose pins behind a single 32-bit register word. A write never carries new pin state directly. Instead, each bit of the written word is a one-shot command. One pair of bits per pin pulls its output level down or up. A second pair turns its pad driver on or off. Bits written as zero do nothing. Several software agents can therefore update their own pins with a single store, without reading the register first and without a lock.

A read returns the level seen at each pad after a two-flop synchronizer. This holds whether the pin is driving or listening. Pads are driven in tri-state form: a level output plus an enable output per pin. The pin count is a parameter of at most eight. A full bank and a four-pin bank use the same bit encoding.

Top module: `gpio_cmd_bank`

## Requirements
- R1: While reset is asserted and after it is released, every pin is an input (pad_oe = 0) with a stored output level of 0 (pad_out = 0).
- R2: A write with bit 2n set and bit 2n+1 clear makes pad_out[n] 0 from the clock edge that takes the write.
- R3: A write with bit 2n+1 set and bit 2n clear makes pad_out[n] 1 from the clock edge that takes the write.
- R4: A write with bit 16+2n set and bit 17+2n clear turns pin n into an output. pad_oe[n] then reads 1.
- R5: A write with bit 17+2n set and bit 16+2n clear turns pin n into an input. pad_oe[n] then reads 0.
- R6: Zero bits in a write, and clock cycles with no write, leave pad_out and pad_oe unchanged.
- R7: If a write sets both level bits of one pin, that pin's level is kept. If it sets both direction bits, the pin's direction is kept.
- R8: Command bits that belong to pin indices at or above NPINS change nothing. Read-back bits for those pins are 0.
- R9: rd_data bit 2n+1 equals the level pad_in[n] had two clock edges earlier, whether the pin is an input or an output. Every even bit of rd_data is 0.
- R10: Software can write a level while pin n is an input and then issue the output command. When pad_oe[n] rises, pad_out[n] already carries that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Command word for the write |
| rd_data | output | 32 | Read-back image of synchronized pad levels |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Stored output level per pin |
| pad_oe | output | NPINS | Pad driver enable per pin (1 = output) |

## Verification
A level command and a direction command for the same pin can arrive in one write. A single store can then make a pin drive high and turn its driver on at once. A write can also carry both halves of a pair, and it is applied in the same cycle that new pad samples advance through the synchronizer. The bench provokes both cases with random command words, which often set both fields of one pin and sometimes both halves of a pair, while pad_in changes at the same time. Each result is judged against a bench model that applies the pin's level and direction commands separately, with the conflict rule. The synchronized read-back is compared two edges after the pad change.

// File: rtl/gpio_cmd_pkg.sv
package gpio_cmd_pkg;
    localparam int GPC_MAX_PINS = 8;
    localparam int GPC_WORD_W   = 32;
    localparam int GPC_DIR_BASE = 2 * GPC_MAX_PINS;

    function automatic int lvl_lo_bit(input int n);
        return 2 * n;
    endfunction

    function automatic int lvl_hi_bit(input int n);
        return 2 * n + 1;
    endfunction

    function automatic int dir_out_bit(input int n);
        return GPC_DIR_BASE + 2 * n;
    endfunction

    function automatic int dir_in_bit(input int n);
        return GPC_DIR_BASE + 2 * n + 1;
    endfunction
endpackage

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
    import gpio_cmd_pkg::*;
(
    input  logic                    wr_en,
    input  logic [GPC_WORD_W-1:0]   wr_data,
    output logic [GPC_MAX_PINS-1:0] drv_lo,
    output logic [GPC_MAX_PINS-1:0] drv_hi,
    output logic [GPC_MAX_PINS-1:0] mk_out,
    output logic [GPC_MAX_PINS-1:0] mk_in
);
    for (genvar n = 0; n < GPC_MAX_PINS; n++) begin : g_pin
        assign drv_lo[n] = wr_en & wr_data[lvl_lo_bit(n)];
        assign drv_hi[n] = wr_en & wr_data[lvl_hi_bit(n)];
        assign mk_out[n] = wr_en & wr_data[dir_out_bit(n)];
        assign mk_in[n]  = wr_en & wr_data[dir_in_bit(n)];
    end
endmodule

// File: rtl/gpio_pin_state.sv
module gpio_pin_state #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] drv_lo,
    input  logic [NPINS-1:0] drv_hi,
    input  logic [NPINS-1:0] mk_out,
    input  logic [NPINS-1:0] mk_in,
    output logic [NPINS-1:0] lvl_q,
    output logic [NPINS-1:0] dir_q
);
    typedef struct packed {
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] dir;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = (st_q.lvl & ~(drv_lo & ~drv_hi)) | (drv_hi & ~drv_lo);
        st_d.dir = (st_q.dir & ~(mk_in & ~mk_out)) | (mk_out & ~mk_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;
    assign dir_q = st_q.dir;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_sync
);
    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] stab;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta = pad_in;
        sy_d.stab = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign pad_sync = sy_q.stab;
endmodule

// File: rtl/gpio_cmd_bank.sv
module gpio_cmd_bank
    import gpio_cmd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [GPC_WORD_W-1:0] wr_data,
    output logic [GPC_WORD_W-1:0] rd_data,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe
);
    logic [GPC_MAX_PINS-1:0] lo_all, hi_all, out_all, in_all;
    logic [NPINS-1:0]        pad_sync;

    gpio_cmd_decode i_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .drv_lo  (lo_all),
        .drv_hi  (hi_all),
        .mk_out  (out_all),
        .mk_in   (in_all)
    );

    if (NPINS < GPC_MAX_PINS) begin : g_narrow
        logic unused_cmds;
        assign unused_cmds = ^{lo_all[GPC_MAX_PINS-1:NPINS], hi_all[GPC_MAX_PINS-1:NPINS],
                               out_all[GPC_MAX_PINS-1:NPINS], in_all[GPC_MAX_PINS-1:NPINS]};
    end

    gpio_pin_state #(.NPINS(NPINS)) i_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .drv_lo (lo_all[NPINS-1:0]),
        .drv_hi (hi_all[NPINS-1:0]),
        .mk_out (out_all[NPINS-1:0]),
        .mk_in  (in_all[NPINS-1:0]),
        .lvl_q  (pad_out),
        .dir_q  (pad_oe)
    );

    gpio_in_sync #(.NPINS(NPINS)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NPINS; n++) begin
            rd_data[lvl_hi_bit(n)] = pad_sync[n];
        end
    end
endmodule

// File: rtl/gpio_cmd_bank_chk.sv
module gpio_cmd_bank_chk
    import gpio_cmd_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [GPC_WORD_W-1:0] wr_data,
    input logic [GPC_WORD_W-1:0] rd_data,
    input logic [NPINS-1:0]      pad_in,
    input logic [NPINS-1:0]      pad_out,
    input logic [NPINS-1:0]      pad_oe
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));

    // R9
    even_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & 32'h5555_5555) == '0);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        // R2
        drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n] && !wr_data[2*n+1] |=> !pad_out[n]);
        // R3
        drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[2*n+1] && !wr_data[2*n] |=> pad_out[n]);
        // R4
        make_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[16+2*n] && !wr_data[17+2*n] |=> pad_oe[n]);
        // R5
        make_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && wr_data[17+2*n] && !wr_data[16+2*n] |=> !pad_oe[n]);
        // R6
        level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_data[2*n] ^ wr_data[2*n+1])) |=> $stable(pad_out[n]));
        // R7
        dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_data[16+2*n] ^ wr_data[17+2*n])) |=> $stable(pad_oe[n]));
        // R9
        sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            since_rst >= 2'd2 |-> rd_data[2*n+1] == $past(pad_in[n], 2));
    end

    for (genvar m = NPINS; m < GPC_MAX_PINS; m++) begin : g_absent
        // R8
        absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[2*m+1] == 1'b0);
    end
endmodule

bind gpio_cmd_bank gpio_cmd_bank_chk #(.NPINS(NPINS)) i_chk (.*);

// File: tb/test_gpio_cmd_bank.sv
`timescale 1ns/1ps
module test_gpio_cmd_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_w, rd_n;
    logic [7:0]  pin_w = '0, out_w, oe_w;
    logic [3:0]  pin_n = '0, out_n, oe_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] st_w = '0;
    logic [15:0] st_n = '0;

    always #2.5 clk = ~clk;

    gpio_cmd_bank #(.NPINS(8)) i_gpio_cmd_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_w), .pad_in(pin_w), .pad_out(out_w), .pad_oe(oe_w)
    );

    gpio_cmd_bank #(.NPINS(4)) i_gpio_cmd_bank_n (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_n), .pad_in(pin_n), .pad_out(out_n), .pad_oe(oe_n)
    );

    function automatic logic [15:0] model_step(logic [15:0] st, logic [31:0] d, int np);
        logic [7:0] lv;
        logic [7:0] dr;
        lv = st[7:0];
        dr = st[15:8];
        for (int n = 0; n < np; n++) begin
            if (d[2*n] && !d[2*n+1]) lv[n] = 1'b0;
            if (d[2*n+1] && !d[2*n]) lv[n] = 1'b1;
            if (d[16+2*n] && !d[17+2*n]) dr[n] = 1'b1;
            if (d[17+2*n] && !d[16+2*n]) dr[n] = 1'b0;
        end
        return {dr, lv};
    endfunction

    function automatic logic [31:0] model_rb(logic [7:0] pins, int np);
        logic [31:0] r;
        r = '0;
        for (int n = 0; n < np; n++) r[2*n+1] = pins[n];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one write plus a pad change; checks pads after one edge, read-back after two
    task automatic step(string req, logic [31:0] d, logic [7:0] pw, logic [3:0] pn);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        pin_w = pw;
        pin_n = pn;
        st_w = model_step(st_w, d, 8);
        st_n = model_step(st_n, d, 4);
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        chk({req, " wide out"}, {24'd0, out_w}, {24'd0, st_w[7:0]});
        chk({req, " wide oe"},  {24'd0, oe_w},  {24'd0, st_w[15:8]});
        chk({req, " narrow out"}, {28'd0, out_n}, {28'd0, st_n[3:0]});
        chk({req, " narrow oe"},  {28'd0, oe_n},  {28'd0, st_n[11:8]});
        @(negedge clk);
        chk({req, " wide rd"},   rd_w, model_rb(pw, 8));
        chk({req, " narrow rd"}, rd_n, model_rb({4'd0, pn}, 4));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", {24'd0, oe_w}, '0);
        chk("R1 out", {24'd0, out_w}, '0);
        chk("R1 narrow oe", {28'd0, oe_n}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {16'd0, oe_w, out_w}, '0);

        step("R10 level first", 32'h0000_0080, 8'h00, 4'h0);  // pin 3 high, still input
        chk("R10 oe low", {31'd0, oe_w[3]}, 32'd0);
        step("R10 then output", 32'h0040_0000, 8'h00, 4'h0);  // pin 3 output
        chk("R10 out held", {30'd0, oe_w[3], out_w[3]}, 32'd3);
        step("R3 high", 32'h0000_AAAA, 8'hA5, 4'h5);
        step("R4 output", 32'h5555_0000, 8'h3C, 4'hC);
        step("R9 rd in output mode", 32'h0, 8'hFF, 4'hF);
        step("R2 low", 32'h0000_5555, 8'h00, 4'h0);
        step("R6 zero write", 32'h0, 8'h81, 4'h9);
        step("R7 both level bits", 32'h0000_FFFF, 8'h18, 4'h2);
        step("R7 both dir bits", 32'hFFFF_0000, 8'h66, 4'h6);
        step("R5 input", 32'hAAAA_0000, 8'h00, 4'h0);
        step("R8 upper pins", 32'hFF00_FF00, 8'hF0, 4'hA);
        chk("R8 narrow out", {28'd0, out_n}, {28'd0, st_n[3:0]});

        for (int i = 0; i < 300; i++) begin
            step("R6 random", $urandom, 8'($urandom), 4'($urandom));
        end

        // R6 idle cycles without a write
        repeat (4) @(negedge clk);
        chk("R6 idle out", {24'd0, out_w}, {24'd0, st_w[7:0]});
        chk("R6 idle oe", {24'd0, oe_w}, {24'd0, st_w[15:8]});
        finish_run();
    end
endmodule